// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block sits on the word path that carries a 32-bit configuration bitstream toward a configuration engine. It never holds the stream back: valid, data and the end-of-stream marker go straight to the downstream side, and ready comes straight back. While the words pass, it counts the accepted words of the current stream. It extracts an encryption indication from one fixed header word and a compression indication from a later fixed header word.

From those two flags and the selected configuration bus width (narrow 16-bit or wide 32-bit), it works out the clock-to-data ratio as a two-bit field code. It also latches the configuration width bit. It registers both results together with a valid flag, one cycle after the second flag word is accepted and well before the payload follows. A stream that ends before the second flag word is reported as a malformed header, and no ratio is given for it.

The word that follows an accepted end-of-stream word starts a new stream. Results hold from one stream until that first word of the next stream is accepted.

Top module: `hdr_ratio_sniffer`

## Requirements
- R1: Words are indexed from 0, starting at the first accepted word of a stream. `ratio_vld_o` goes to 1 in the cycle after the handshake of word 229. `ratio_vld_o`, `ratio_code_o` and `cfg_wide_o` then hold until the first word of the next stream is accepted. One cycle after that handshake, `ratio_vld_o` and `hdr_err_o` read 0.
- R2: A stream counts as encrypted when bits [3:2] of word 69 are not both zero. All other bits of word 69 have no effect.
- R3: A stream counts as compressed when bit 1 of word 229 is 0, so the indication is active low. All other bits of word 229 have no effect.
- R4: With `wide_sel_i` = 0 (narrow bus), the code uses x1 = 0, x2 = 1, x4 = 2 and x8 = 3. No flag gives 0 (x1). Encryption alone gives 1 (x2). Compression, with or without encryption, gives 2 (x4).
- R5: With `wide_sel_i` = 1 (wide bus), the code is one step above the narrow code whenever any flag is set. No flag gives 0 (x1). Encryption alone gives 2 (x4). Compression gives 3 (x8).
- R6: `cfg_wide_o` takes the value of `wide_sel_i` sampled at the handshake of word 229, together with the code.
- R7: If the end-of-stream word is accepted at an index below 229, `hdr_err_o` goes to 1 in the next cycle. `ratio_vld_o` stays 0 for that stream. Whenever `ratio_vld_o` is 0, `ratio_code_o` reads 0.
- R8: `m_valid_o`, `m_data_o` and `m_last_o` equal `s_valid_i`, `s_data_i` and `s_last_i`, and `s_ready_o` equals `m_ready_i`, in the same cycle.
- R9: A word presented while `m_ready_i` is 0 does not advance the word index and changes no result.
- R10: After reset, `ratio_vld_o`, `hdr_err_o`, `ratio_code_o` and `cfg_wide_o` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_sel_i | input | 1 | Bus width select: 1 for the wide bus, 0 for the narrow bus |
| s_valid_i | input | 1 | Upstream word valid |
| s_ready_o | output | 1 | Upstream ready, equal to m_ready_i |
| s_data_i | input | DATA_W | Upstream word |
| s_last_i | input | 1 | Marks the last word of a stream |
| m_valid_o | output | 1 | Downstream word valid |
| m_ready_i | input | 1 | Downstream ready |
| m_data_o | output | DATA_W | Downstream word |
| m_last_o | output | 1 | Downstream end-of-stream marker |
| ratio_code_o | output | 2 | Clock-to-data ratio field code |
| ratio_vld_o | output | 1 | Ratio code and width bit are valid |
| hdr_err_o | output | 1 | Stream ended before the header was complete |
| cfg_wide_o | output | 1 | Configuration width bit |

## Verification
A wrong word index shows at the ports one cycle after a handshake that the model treats differently. The valid flag rises early or late, or the error flag rises on a stream of legal length. A lost or stale encryption flag stays hidden until word 229. The code then lands one or two steps away from the expected value, and that value persists for the rest of the payload. So every stream is compared clock by clock, across all flag and width combinations, with stalls and boundary lengths of 1, 229 and 230 words.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

   typedef enum logic [1:0] {
      RATIO_X1 = 2'd0,
      RATIO_X2 = 2'd1,
      RATIO_X4 = 2'd2,
      RATIO_X8 = 2'd3
   } ratio_code_e;

   // Narrow-bus code for a flag pair; compression dominates encryption.
   function automatic ratio_code_e narrow_code(input logic enc, input logic cmp);
      if (cmp)
         return RATIO_X4;
      else if (enc)
         return RATIO_X2;
      else
         return RATIO_X1;
   endfunction

endpackage

// File: rtl/hrs_word_idx.sv
module hrs_word_idx #(
   parameter int ENC_IDX = 69,
   parameter int CMP_IDX = 229,
   localparam int CNT_MAX = CMP_IDX + 1,
   localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs,
   input  logic last,
   output logic first,
   output logic at_enc,
   output logic at_cmp,
   output logic short_end
);

   logic [CNT_W-1:0] cnt_q;

   assign first     = (cnt_q == '0);
   assign at_enc    = (cnt_q == CNT_W'(ENC_IDX));
   assign at_cmp    = (cnt_q == CNT_W'(CMP_IDX));
   assign short_end = hs & last & (cnt_q < CNT_W'(CMP_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hs) begin
         if (last)
            cnt_q <= '0;
         else if (cnt_q != CNT_W'(CNT_MAX))
            cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/hrs_flag_grab.sv
module hrs_flag_grab #(
   parameter int ENC_W          = 2,
   parameter bit CMP_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_load,
   input  logic [ENC_W-1:0] enc_field,
   input  logic             cmp_raw,
   output logic             enc_flag,
   output logic             cmp_flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         enc_flag <= 1'b0;
      else if (enc_load)
         enc_flag <= |enc_field;
   end

   generate
      if (CMP_ACTIVE_LOW) begin : g_cmp_low
         assign cmp_flag = ~cmp_raw;
      end else begin : g_cmp_high
         assign cmp_flag = cmp_raw;
      end
   endgenerate

endmodule

// File: rtl/hrs_ratio_enc.sv
module hrs_ratio_enc
   import hrs_pkg::*;
#(
   parameter int MAP_STYLE = 0
) (
   input  logic        enc,
   input  logic        cmp,
   input  logic        wide,
   output ratio_code_e code
);

   generate
      if (MAP_STYLE == 0) begin : g_bump
         // Narrow code, raised one step on the wide bus when any flag is set.
         ratio_code_e base;
         always_comb begin
            base = narrow_code(enc, cmp);
            if (wide && (enc || cmp))
               code = ratio_code_e'(base + 2'd1);
            else
               code = base;
         end
      end else begin : g_table
         always_comb begin
            unique case ({wide, cmp, enc})
               3'b000:          code = RATIO_X1;
               3'b001:          code = RATIO_X2;
               3'b010, 3'b011:  code = RATIO_X4;
               3'b100:          code = RATIO_X1;
               3'b101:          code = RATIO_X4;
               default:         code = RATIO_X8;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/hdr_ratio_sniffer.sv
module hdr_ratio_sniffer
   import hrs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ENC_IDX   = 69,
   parameter int ENC_LSB   = 2,
   parameter int ENC_W     = 2,
   parameter int CMP_IDX   = 229,
   parameter int CMP_BIT   = 1,
   parameter int MAP_STYLE = 0,
   localparam int ENC_MSB  = ENC_LSB + ENC_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_sel_i,
   input  logic              s_valid_i,
   output logic              s_ready_o,
   input  logic [DATA_W-1:0] s_data_i,
   input  logic              s_last_i,
   output logic              m_valid_o,
   input  logic              m_ready_i,
   output logic [DATA_W-1:0] m_data_o,
   output logic              m_last_o,
   output logic [1:0]        ratio_code_o,
   output logic              ratio_vld_o,
   output logic              hdr_err_o,
   output logic              cfg_wide_o
);

   generate
      if (DATA_W < 32) begin : g_bad_width
         $error("hdr_ratio_sniffer: DATA_W must be at least 32");
      end
      if (ENC_IDX >= CMP_IDX) begin : g_bad_order
         $error("hdr_ratio_sniffer: ENC_IDX must precede CMP_IDX");
      end
      if (ENC_MSB >= DATA_W || CMP_BIT >= DATA_W) begin : g_bad_field
         $error("hdr_ratio_sniffer: flag field outside word");
      end
      if (MAP_STYLE < 0 || MAP_STYLE > 1) begin : g_bad_map
         $error("hdr_ratio_sniffer: MAP_STYLE must be 0 or 1");
      end
   endgenerate

   // Straight pass-through: the snooper never stalls.
   assign m_valid_o = s_valid_i;
   assign m_data_o  = s_data_i;
   assign m_last_o  = s_last_i;
   assign s_ready_o = m_ready_i;

   logic hs;
   assign hs = s_valid_i & m_ready_i;

   logic first, at_enc, at_cmp, short_end;

   hrs_word_idx #(
      .ENC_IDX (ENC_IDX),
      .CMP_IDX (CMP_IDX)
   ) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs        (hs),
      .last      (s_last_i),
      .first     (first),
      .at_enc    (at_enc),
      .at_cmp    (at_cmp),
      .short_end (short_end)
   );

   logic enc_flag, cmp_flag;

   hrs_flag_grab #(
      .ENC_W          (ENC_W),
      .CMP_ACTIVE_LOW (1'b1)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .enc_load  (hs & at_enc),
      .enc_field (s_data_i[ENC_MSB:ENC_LSB]),
      .cmp_raw   (s_data_i[CMP_BIT]),
      .enc_flag  (enc_flag),
      .cmp_flag  (cmp_flag)
   );

   ratio_code_e code_nxt;

   hrs_ratio_enc #(
      .MAP_STYLE (MAP_STYLE)
   ) u_enc (
      .enc  (enc_flag),
      .cmp  (cmp_flag),
      .wide (wide_sel_i),
      .code (code_nxt)
   );

   ratio_code_e code_q;
   logic        vld_q, err_q, wide_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= RATIO_X1;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
         wide_q <= 1'b0;
      end else if (hs) begin
         if (first) begin
            code_q <= RATIO_X1;
            vld_q  <= 1'b0;
            err_q  <= 1'b0;
         end
         if (at_cmp) begin
            code_q <= code_nxt;
            vld_q  <= 1'b1;
            wide_q <= wide_sel_i;
         end
         if (short_end)
            err_q <= 1'b1;
      end
   end

   assign ratio_code_o = code_q;
   assign ratio_vld_o  = vld_q;
   assign hdr_err_o    = err_q;
   assign cfg_wide_o   = wide_q;

endmodule

// File: rtl/hrs_checker.sv
module hrs_checker #(
   parameter int CMP_IDX = 229
) (
   input logic       clk,
   input logic       rst_n,
   input logic       s_valid_i,
   input logic       s_last_i,
   input logic       m_ready_i,
   input logic [1:0] ratio_code_o,
   input logic       ratio_vld_o,
   input logic       hdr_err_o,
   input logic       cfg_wide_o
);

   logic hs;
   int   ck_cnt;

   assign hs = s_valid_i && m_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ck_cnt <= 0;
      else if (hs)
         ck_cnt <= s_last_i ? 0 : ((ck_cnt <= CMP_IDX) ? ck_cnt + 1 : ck_cnt);
   end

   AST_VLD_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      hs && ck_cnt == CMP_IDX |=> ratio_vld_o) else $error("vld late"); // R1
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_vld_o && !(hs && ck_cnt == 0) |=>
         ratio_vld_o && $stable(ratio_code_o) && $stable(cfg_wide_o)) else $error("hold"); // R1
   AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_vld_o && !cfg_wide_o |-> ratio_code_o != 2'd3) else $error("narrow"); // R4
   AST_WIDE_SKIP_X2: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_vld_o && cfg_wide_o |-> ratio_code_o != 2'd1) else $error("wide"); // R5
   AST_SHORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      hs && s_last_i && ck_cnt < CMP_IDX |=> hdr_err_o && !ratio_vld_o) else $error("short"); // R7
   AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ratio_vld_o |-> ratio_code_o == 2'd0) else $error("idle code"); // R7
   AST_STALL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid_i && !m_ready_i |=> !$rose(ratio_vld_o) && !$rose(hdr_err_o)) else $error("stall"); // R9

endmodule

bind hdr_ratio_sniffer hrs_checker #(.CMP_IDX(CMP_IDX)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .s_valid_i    (s_valid_i),
   .s_last_i     (s_last_i),
   .m_ready_i    (m_ready_i),
   .ratio_code_o (ratio_code_o),
   .ratio_vld_o  (ratio_vld_o),
   .hdr_err_o    (hdr_err_o),
   .cfg_wide_o   (cfg_wide_o)
);

// File: tb/hdr_ratio_sniffer_bench.sv
module hdr_ratio_sniffer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_sel_i = 1'b0;
   logic        s_valid_i = 1'b0;
   logic        s_ready_o;
   logic [31:0] s_data_i = '0;
   logic        s_last_i = 1'b0;
   logic        m_valid_o;
   logic        m_ready_i = 1'b1;
   logic [31:0] m_data_o;
   logic        m_last_o;
   logic [1:0]  ratio_code_o;
   logic        ratio_vld_o, hdr_err_o, cfg_wide_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   hdr_ratio_sniffer u_hdr_ratio_sniffer (
      .clk(clk), .rst_n(rst_n), .wide_sel_i(wide_sel_i),
      .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
      .s_last_i(s_last_i), .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
      .m_data_o(m_data_o), .m_last_o(m_last_o), .ratio_code_o(ratio_code_o),
      .ratio_vld_o(ratio_vld_o), .hdr_err_o(hdr_err_o), .cfg_wide_o(cfg_wide_o)
   );

   // Behavioural reference model, advanced on every clock.
   int   m_idx  = 0;
   bit   m_enc  = 0;
   bit   e_vld  = 0;
   bit   e_err  = 0;
   bit   e_wide = 0;
   int   e_code = 0;

   function automatic int ref_code(bit enc, bit cmp, bit wide);
      if (!enc && !cmp) return 0;
      if (!wide) return cmp ? 2 : 1;
      return cmp ? 3 : 2;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_idx = 0; m_enc = 0; e_vld = 0; e_err = 0; e_wide = 0; e_code = 0;
      end else if (s_valid_i && m_ready_i) begin
         if (m_idx == 0) begin e_vld = 0; e_err = 0; e_code = 0; end
         if (m_idx == 69) m_enc = (s_data_i[3:2] != 2'b00);
         if (m_idx == 229) begin
            e_code = ref_code(m_enc, !s_data_i[1], wide_sel_i);
            e_vld  = 1;
            e_wide = wide_sel_i;
         end
         if (s_last_i && m_idx < 229) e_err = 1;
         if (s_last_i) m_idx = 0;
         else if (m_idx < 1000) m_idx = m_idx + 1;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Clock-by-clock comparison, 2 ns after the rising edge.
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R1 ratio_vld", int'(ratio_vld_o), int'(e_vld));
         chk("R7 hdr_err", int'(hdr_err_o), int'(e_err));
         chk(e_wide ? "R5 code" : "R4 code", int'(ratio_code_o), e_code);
         chk("R6 cfg_wide", int'(cfg_wide_o), int'(e_wide));
         chk("R8 pass", int'({m_valid_o, m_last_o, s_ready_o}),
             int'({s_valid_i, s_last_i, m_ready_i}));
         chk("R8 data", int'(m_data_o == s_data_i), 1);
      end
   end

   task automatic send(int len, logic [31:0] w69, logic [31:0] w229, bit wide, int gap);
      wide_sel_i = wide;
      for (int i = 0; i < len; i++) begin
         bit took;
         s_valid_i = 1'b1;
         s_data_i  = (i == 69) ? w69 : (i == 229) ? w229 : $urandom;
         s_last_i  = (i == len - 1);
         do begin
            m_ready_i = (gap == 0) ? 1'b1 : (($urandom % gap) != 0);
            @(posedge clk);
            took = m_ready_i;
            @(negedge clk);
         end while (!took);
      end
      s_valid_i = 1'b0;
      s_last_i  = 1'b0;
      m_ready_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_res(string tag, bit vld, bit err, int code, bit wide);
      chk({tag, " vld"},  int'(ratio_vld_o), int'(vld));
      chk({tag, " err"},  int'(hdr_err_o), int'(err));
      chk({tag, " code"}, int'(ratio_code_o), code);
      chk({tag, " wide"}, int'(cfg_wide_o), int'(wide));
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_res("R10 reset", 0, 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2/R3/R4: narrow bus, all flag combinations
      send(260, 32'h0, 32'h2, 0, 0);           expect_res("R4 none", 1, 0, 0, 0);
      send(260, 32'h4, 32'h2, 0, 0);           expect_res("R2 enc narrow", 1, 0, 1, 0);
      send(260, 32'h0, 32'h0, 0, 0);           expect_res("R3 cmp narrow", 1, 0, 2, 0);
      send(260, 32'h8, 32'h0, 0, 0);           expect_res("R4 both narrow", 1, 0, 2, 0);
      // R5/R6: wide bus
      send(260, 32'h0, 32'hFFFF_FFFF, 1, 0);   expect_res("R5 none wide", 1, 0, 0, 1);
      send(260, 32'hC, 32'h2, 1, 0);           expect_res("R5 enc wide", 1, 0, 2, 1);
      send(260, 32'h0, 32'hFFFF_FFFD, 1, 0);   expect_res("R5 cmp wide", 1, 0, 3, 1);
      send(260, 32'h4, 32'h0, 1, 0);           expect_res("R5 both wide", 1, 0, 3, 1);
      // R2/R3: other bits in the flag words have no effect
      send(240, 32'hFFFF_FFF3, 32'h0000_0002, 0, 0); expect_res("R2 other bits", 1, 0, 0, 0);
      // R9: random stalls
      send(300, 32'h4, 32'h0, 1, 3);           expect_res("R9 stalls", 1, 0, 3, 1);
      // R7: short streams; boundary at 229 and 230 words
      send(229, 32'h4, 32'h0, 0, 0);           expect_res("R7 len229", 0, 1, 0, 1);
      send(1, 32'h0, 32'h0, 0, 0);             expect_res("R7 len1", 0, 1, 0, 1);
      send(230, 32'h4, 32'h2, 0, 2);           expect_res("R1 len230", 1, 0, 1, 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule